// File: doc/BRIEF.md
# Banked FM Register Write Decoder

This block sits between a host byte bus and the voice engine of a six-voice, four-operator FM synthesizer. The host sees four byte locations. The even locations pick a register number, one bank per pair. The odd locations carry the data byte for the register picked in that bank. The decoder turns each data write into a typed, single-cycle strobe with its payload already split out. The payloads are timer reloads, key commands, frequency words, algorithm selects, PCM samples, and per-operator parameter bytes. Each strobe carries the channel and operator indices decoded from the register number.

Some fields span two registers: the timer A reload value and the per-channel frequency word. The decoder keeps the last value of every part, so each strobe presents the whole, current field. A read at any location returns the two timer overflow flags, which are inputs from the timer logic. Timer counting and sound generation are handled elsewhere.

Top module: `fm_reg_decoder`

## Requirements
- R1: A write at offset 0 (bank 0) or offset 2 (bank 1) stores the data byte as that bank's selected register number. A write at offset 1 or 3 applies the data to the register selected in bank 0 or bank 1. When the bank's selection is 0, the data write is ignored. Each decoded strobe is high for exactly the one cycle after the data write.
- R2: Registers 0x30 to 0x9F whose low two bits are not both 1 raise op_stb. The payload is: op_group = (register bits 7:4) minus 3; op_chan = register bits 1:0 plus 3 for bank 1; op_idx = register bits 3:2; op_data = the raw byte. For group 1 (0x40), bits 6:0 are the attenuation in 0.75 dB steps with 0 loudest. For group 0 (0x30), bits 3:0 are the multiplier.
- R3: Timer A is a 10-bit value. Register 0x24 loads bits 9:2 from data bits 7:0. Register 0x25 loads bits 1:0 from data bits 1:0. Each of these writes raises ta_stb with the full 10-bit value, including the part that was not written.
- R4: Register 0x26 raises tb_stb and sets tb_value to the data byte.
- R5: Register 0x28 is a key command. When data bits 2:0 are below 6, it raises key_stb with key_chan = data bits 2:0 and key_mask = data bits 7:4. The strobe also tells the voice engine to restart that channel's phase. Channel codes 6 and 7 raise nothing.
- R6: Registers 0xA0 to 0xA2 store the low 8 bits of the channel's 11-bit frequency number. Registers 0xA4 to 0xA6 store bits 10:8 from data bits 2:0 and the 3-bit block from data bits 5:3. The channel is register bits 1:0 plus 3 for bank 1. Either write raises freq_stb with that channel's full stored frequency number and block.
- R7: Registers 0xB0 to 0xB2 raise alg_stb with alg_sel = data bits 2:0 and alg_chan decoded as in R6.
- R8: Register 0x2B sets the level pcm_en to data bit 7. Register 0x2A raises pcm_stb with the data byte only while pcm_en is 1; otherwise the write has no effect.
- R9: While bus_rd is high, bus_rdata is {6'b0, tmr_a_ovf, tmr_b_ovf} at every offset. Otherwise it is 0.
- R10: A write to any other register, including 0xA3, 0xA7, 0xB3 and any 0x30–0x9F register whose low bits are 11, raises no strobe. At most one strobe is high in any cycle.
- R11: Synchronous active-low reset clears both bank selections, all strobes, pcm_en, the stored timer A value and every stored frequency part.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write enable |
| bus_rd | input | 1 | Read enable |
| bus_addr | input | 2 | Byte offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Status byte |
| tmr_a_ovf | input | 1 | Timer A overflow flag |
| tmr_b_ovf | input | 1 | Timer B overflow flag |
| ta_stb | output | 1 | Timer A reload strobe |
| ta_value | output | 10 | Timer A reload value |
| tb_stb | output | 1 | Timer B reload strobe |
| tb_value | output | 8 | Timer B reload value |
| key_stb | output | 1 | Key command and phase restart strobe |
| key_chan | output | 3 | Key command channel |
| key_mask | output | 4 | Operator on mask |
| freq_stb | output | 1 | Frequency update strobe |
| freq_chan | output | 3 | Frequency channel |
| freq_fnum | output | 11 | Frequency number |
| freq_block | output | 3 | Octave block |
| alg_stb | output | 1 | Algorithm strobe |
| alg_chan | output | 3 | Algorithm channel |
| alg_sel | output | 3 | Algorithm select |
| pcm_en | output | 1 | PCM enable level |
| pcm_stb | output | 1 | PCM sample strobe |
| pcm_data | output | 8 | PCM sample byte |
| op_stb | output | 1 | Operator parameter strobe |
| op_group | output | 3 | Parameter group, 0 for 0x30 up to 6 for 0x90 |
| op_chan | output | 3 | Operator channel |
| op_idx | output | 2 | Operator index |
| op_data | output | 8 | Operator parameter byte |

## Verification
The bench builds the decoder with its default of three voices per bank, which gives six channels. With that setting, every channel slot in both banks is reachable, and so is the skipped fourth slot of each register group. The bench sweeps the whole operator register range in bank 0 and part of it in bank 1. It checks that the two halves of each split field combine in either write order. It also checks that each bank's selection stays separate from the other's while data writes interleave.

// File: rtl/fm_dec_pkg.sv
// Shared register numbers and the decode class for the FM register decoder.
package fm_dec_pkg;

    typedef enum logic [3:0] {
        K_NONE, K_TA_HI, K_TA_LO, K_TB, K_KEY, K_PCM_D, K_PCM_EN,
        K_OP, K_FLO, K_FHI, K_ALG
    } reg_kind_e;

    localparam logic [7:0] RN_TA_HI  = 8'h24;
    localparam logic [7:0] RN_TA_LO  = 8'h25;
    localparam logic [7:0] RN_TB     = 8'h26;
    localparam logic [7:0] RN_KEY    = 8'h28;
    localparam logic [7:0] RN_PCM_D  = 8'h2A;
    localparam logic [7:0] RN_PCM_EN = 8'h2B;
    localparam logic [3:0] OP_FIRST  = 4'h3;
    localparam logic [3:0] OP_LAST   = 4'h9;
    localparam logic [5:0] QD_FLO    = 6'b101000;
    localparam logic [5:0] QD_FHI    = 6'b101001;
    localparam logic [5:0] QD_ALG    = 6'b101100;

endpackage

// File: rtl/fm_bank_latch.sv
// Register-number latch for one bank.
// Assumes: ld is a single-cycle write to the bank's even offset.
module fm_bank_latch (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ld,
    input  logic [7:0] din,
    output logic [7:0] sel
);
    // Hold the last register number written to this bank.
    always_ff @(posedge clk) begin
        if (!rst_n)  sel <= '0;
        else if (ld) sel <= din;
    end
endmodule

// File: rtl/fm_reg_classify.sv
// Combinational classification of a register number into a decode class,
// with its channel and operator indices.
// Assumes: VPB <= 3, so register bits 1:0 address the voices of one bank.
module fm_reg_classify
    import fm_dec_pkg::*;
#(
    parameter int VPB  = 3,
    parameter int CH_W = 3
) (
    input  logic [7:0]      reg_num,
    input  logic            bank,
    output reg_kind_e       kind,
    output logic [CH_W-1:0] chan,
    output logic [1:0]      op
);
    logic slot_ok;

    assign slot_ok = (32'(reg_num[1:0]) < VPB);
    assign chan    = CH_W'(reg_num[1:0]) + (bank ? CH_W'(VPB) : '0);
    assign op      = reg_num[3:2];

    // Map the register number onto its decode class.
    always_comb begin
        kind = K_NONE;
        if (reg_num == RN_TA_HI)                                   kind = K_TA_HI;
        else if (reg_num == RN_TA_LO)                              kind = K_TA_LO;
        else if (reg_num == RN_TB)                                 kind = K_TB;
        else if (reg_num == RN_KEY)                                kind = K_KEY;
        else if (reg_num == RN_PCM_D)                              kind = K_PCM_D;
        else if (reg_num == RN_PCM_EN)                             kind = K_PCM_EN;
        else if (reg_num[7:4] >= OP_FIRST && reg_num[7:4] <= OP_LAST && slot_ok)
                                                                   kind = K_OP;
        else if (reg_num[7:2] == QD_FLO && slot_ok)                kind = K_FLO;
        else if (reg_num[7:2] == QD_FHI && slot_ok)                kind = K_FHI;
        else if (reg_num[7:2] == QD_ALG && slot_ok)                kind = K_ALG;
    end
endmodule

// File: rtl/fm_freq_store.sv
// Per-channel frequency word store; merges the low and high writes into one
// update strobe carrying the channel's complete frequency number and block.
// Assumes: at most one of we_lo/we_hi is high and chan < NUM_CH.
module fm_freq_store #(
    parameter int NUM_CH = 6,
    parameter int CH_W   = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we_lo,
    input  logic            we_hi,
    input  logic [CH_W-1:0] chan,
    input  logic [7:0]      din,
    output logic            stb,
    output logic [CH_W-1:0] chan_o,
    output logic [10:0]     fnum,
    output logic [2:0]      block
);
    logic [7:0] lo_q  [NUM_CH];
    logic [2:0] hi_q  [NUM_CH];
    logic [2:0] blk_q [NUM_CH];

    // Store the written part and present the merged word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_CH; i++) begin
                lo_q[i]  <= '0;
                hi_q[i]  <= '0;
                blk_q[i] <= '0;
            end
            stb    <= 1'b0;
            chan_o <= '0;
            fnum   <= '0;
            block  <= '0;
        end else begin
            stb <= we_lo | we_hi;
            if (we_lo) begin
                lo_q[chan] <= din;
                chan_o     <= chan;
                fnum       <= {hi_q[chan], din};
                block      <= blk_q[chan];
            end else if (we_hi) begin
                hi_q[chan]  <= din[2:0];
                blk_q[chan] <= din[5:3];
                chan_o      <= chan;
                fnum        <= {din[2:0], lo_q[chan]};
                block       <= din[5:3];
            end
        end
    end
endmodule

// File: rtl/fm_reg_decoder.sv
// Banked register write decoder for a six-voice FM synthesizer.
// Two bank latches select register numbers; data writes become one-cycle
// typed strobes. Reads return the timer overflow flags.
// Assumes: one bus access per cycle; status flags come from the timer block.
module fm_reg_decoder
    import fm_dec_pkg::*;
#(
    parameter int VOICES_PER_BANK = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [1:0]  bus_addr,
    input  logic [7:0]  bus_wdata,
    output logic [7:0]  bus_rdata,
    input  logic        tmr_a_ovf,
    input  logic        tmr_b_ovf,
    output logic        ta_stb,
    output logic [9:0]  ta_value,
    output logic        tb_stb,
    output logic [7:0]  tb_value,
    output logic        key_stb,
    output logic [2:0]  key_chan,
    output logic [3:0]  key_mask,
    output logic        freq_stb,
    output logic [2:0]  freq_chan,
    output logic [10:0] freq_fnum,
    output logic [2:0]  freq_block,
    output logic        alg_stb,
    output logic [2:0]  alg_chan,
    output logic [2:0]  alg_sel,
    output logic        pcm_en,
    output logic        pcm_stb,
    output logic [7:0]  pcm_data,
    output logic        op_stb,
    output logic [2:0]  op_group,
    output logic [2:0]  op_chan,
    output logic [1:0]  op_idx,
    output logic [7:0]  op_data
);
    localparam int NUM_CH = 2 * VOICES_PER_BANK;
    localparam int CH_W   = 3;

    logic [7:0]      sel [2];
    logic [7:0]      cur_sel;
    logic            data_wr;
    reg_kind_e       kind;
    logic [CH_W-1:0] dchan;
    logic [1:0]      dop;

    // One latch per bank.
    for (genvar b = 0; b < 2; b++) begin : g_bank
        fm_bank_latch u_lat (
            .clk   (clk),
            .rst_n (rst_n),
            .ld    (bus_wr && !bus_addr[0] && (bus_addr[1] == 1'(b))),
            .din   (bus_wdata),
            .sel   (sel[b])
        );
    end

    assign cur_sel = sel[bus_addr[1]];
    assign data_wr = bus_wr && bus_addr[0] && (cur_sel != 8'h00);

    fm_reg_classify #(.VPB(VOICES_PER_BANK), .CH_W(CH_W)) u_cls (
        .reg_num (cur_sel),
        .bank    (bus_addr[1]),
        .kind    (kind),
        .chan    (dchan),
        .op      (dop)
    );

    fm_freq_store #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_freq (
        .clk    (clk),
        .rst_n  (rst_n),
        .we_lo  (data_wr && kind == K_FLO),
        .we_hi  (data_wr && kind == K_FHI),
        .chan   (dchan),
        .din    (bus_wdata),
        .stb    (freq_stb),
        .chan_o (freq_chan),
        .fnum   (freq_fnum),
        .block  (freq_block)
    );

    // Status byte on read.
    assign bus_rdata = bus_rd ? {6'b0, tmr_a_ovf, tmr_b_ovf} : 8'h00;

    // Register the decoded fields and raise the matching strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ta_stb <= 1'b0; ta_value <= '0;
            tb_stb <= 1'b0; tb_value <= '0;
            key_stb <= 1'b0; key_chan <= '0; key_mask <= '0;
            alg_stb <= 1'b0; alg_chan <= '0; alg_sel <= '0;
            pcm_en <= 1'b0; pcm_stb <= 1'b0; pcm_data <= '0;
            op_stb <= 1'b0; op_group <= '0; op_chan <= '0; op_idx <= '0; op_data <= '0;
        end else begin
            ta_stb  <= 1'b0;
            tb_stb  <= 1'b0;
            key_stb <= 1'b0;
            alg_stb <= 1'b0;
            pcm_stb <= 1'b0;
            op_stb  <= 1'b0;
            if (data_wr) begin
                case (kind)
                    K_TA_HI: begin ta_stb <= 1'b1; ta_value <= {bus_wdata, ta_value[1:0]}; end
                    K_TA_LO: begin ta_stb <= 1'b1; ta_value <= {ta_value[9:2], bus_wdata[1:0]}; end
                    K_TB:    begin tb_stb <= 1'b1; tb_value <= bus_wdata; end
                    K_KEY: begin
                        if (32'(bus_wdata[2:0]) < NUM_CH) begin
                            key_stb  <= 1'b1;
                            key_chan <= bus_wdata[2:0];
                            key_mask <= bus_wdata[7:4];
                        end
                    end
                    K_PCM_EN: pcm_en <= bus_wdata[7];
                    K_PCM_D: begin
                        if (pcm_en) begin
                            pcm_stb  <= 1'b1;
                            pcm_data <= bus_wdata;
                        end
                    end
                    K_OP: begin
                        op_stb   <= 1'b1;
                        op_group <= 3'(cur_sel[7:4] - OP_FIRST);
                        op_chan  <= dchan;
                        op_idx   <= dop;
                        op_data  <= bus_wdata;
                    end
                    K_ALG: begin
                        alg_stb  <= 1'b1;
                        alg_chan <= dchan;
                        alg_sel  <= bus_wdata[2:0];
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/fm_reg_decoder_chk.sv
// Assertion checker for fm_reg_decoder, attached by bind.
// Assumes: port names match the decoder's.
module fm_reg_decoder_chk #(
    parameter int VOICES_PER_BANK = 3
) (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_wr,
    input logic       bus_rd,
    input logic [1:0] bus_addr,
    input logic [7:0] bus_rdata,
    input logic       ta_stb,
    input logic       tb_stb,
    input logic       key_stb,
    input logic [2:0] key_chan,
    input logic       freq_stb,
    input logic [2:0] freq_chan,
    input logic       alg_stb,
    input logic       pcm_en,
    input logic       pcm_stb,
    input logic       op_stb,
    input logic [2:0] op_group,
    input logic [2:0] op_chan
);
    localparam int NUM_CH = 2 * VOICES_PER_BANK;

    logic [6:0] strobes;
    assign strobes = {ta_stb, tb_stb, key_stb, freq_stb, alg_stb, pcm_stb, op_stb};

    assert_one_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(strobes));

    assert_strobe_needs_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (|strobes) |-> $past(bus_wr && bus_addr[0]));

    assert_key_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        key_stb |-> (32'(key_chan) < NUM_CH));

    assert_pcm_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pcm_stb |-> pcm_en);

    assert_op_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        op_stb |-> (32'(op_chan) < NUM_CH && op_group <= 3'd6));

    assert_freq_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        freq_stb |-> (32'(freq_chan) < NUM_CH));

    assert_quiet_after_reset_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (strobes == 7'd0 && !pcm_en));

    assert_status_upper_R9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |-> (bus_rdata[7:2] == 6'd0));
endmodule

bind fm_reg_decoder fm_reg_decoder_chk #(.VOICES_PER_BANK(VOICES_PER_BANK)) u_chk (.*);

// File: tb/fm_reg_decoder_bench.sv
module fm_reg_decoder_bench;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        bus_wr = 0, bus_rd = 0;
    logic [1:0]  bus_addr = 0;
    logic [7:0]  bus_wdata = 0;
    logic [7:0]  bus_rdata;
    logic        tmr_a_ovf = 0, tmr_b_ovf = 0;
    logic        ta_stb, tb_stb, key_stb, freq_stb, alg_stb, pcm_en, pcm_stb, op_stb;
    logic [9:0]  ta_value;
    logic [7:0]  tb_value, pcm_data, op_data;
    logic [2:0]  key_chan, freq_chan, freq_block, alg_chan, alg_sel, op_group, op_chan;
    logic [3:0]  key_mask;
    logic [10:0] freq_fnum;
    logic [1:0]  op_idx;

    int total = 0, bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    fm_reg_decoder u_fm_reg_decoder (.*);

    // Behavioural reference model state
    int lat [2];
    int ta_m, tb_m, pen_m;
    int flo [6], fhi [6], fblk [6];
    int e_ta, e_tb, e_key, e_frq, e_alg, e_pcm, e_op;
    int v_ta, v_tb, v_kc, v_km, v_fc, v_fn, v_fb, v_ac, v_as, v_pd, v_og, v_oc, v_oi, v_od;

    task automatic check(input string req, input int act, input int exp_v, input string what);
        total++;
        if (act != exp_v) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp_v);
        end
    endtask

    task automatic finish_report();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // Model: interpret each bus write at the clock edge
    always @(posedge clk) begin
        int b, r, d, ch;
        e_ta = 0; e_tb = 0; e_key = 0; e_frq = 0; e_alg = 0; e_pcm = 0; e_op = 0;
        if (!rst_n) begin
            lat[0] = 0; lat[1] = 0; ta_m = 0; tb_m = 0; pen_m = 0;
            for (int i = 0; i < 6; i++) begin flo[i] = 0; fhi[i] = 0; fblk[i] = 0; end
        end else if (bus_wr) begin
            b = bus_addr / 2;
            d = bus_wdata;
            if (bus_addr % 2 == 0) lat[b] = d;
            else if (lat[b] != 0) begin
                r = lat[b];
                ch = (r % 4) + 3 * b;
                if (r == 'h24) begin ta_m = d * 4 + ta_m % 4; e_ta = 1; v_ta = ta_m; end
                else if (r == 'h25) begin ta_m = (ta_m / 4) * 4 + d % 4; e_ta = 1; v_ta = ta_m; end
                else if (r == 'h26) begin e_tb = 1; v_tb = d; end
                else if (r == 'h28) begin
                    if (d % 8 < 6) begin e_key = 1; v_kc = d % 8; v_km = d / 16; end
                end
                else if (r == 'h2A) begin if (pen_m == 1) begin e_pcm = 1; v_pd = d; end end
                else if (r == 'h2B) pen_m = d / 128;
                else if (r >= 'h30 && r <= 'h9F && r % 4 != 3) begin
                    e_op = 1; v_og = r / 16 - 3; v_oc = ch; v_oi = (r / 4) % 4; v_od = d;
                end
                else if (r >= 'hA0 && r <= 'hA2) begin
                    flo[ch] = d; e_frq = 1; v_fc = ch; v_fn = fhi[ch] * 256 + d; v_fb = fblk[ch];
                end
                else if (r >= 'hA4 && r <= 'hA6) begin
                    fhi[ch] = d % 8; fblk[ch] = (d / 8) % 8;
                    e_frq = 1; v_fc = ch; v_fn = fhi[ch] * 256 + flo[ch]; v_fb = fblk[ch];
                end
                else if (r >= 'hB0 && r <= 'hB2) begin e_alg = 1; v_ac = ch; v_as = d % 8; end
            end
        end
    end

    // Compare the design against the model on every clock
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R3", ta_stb, e_ta, "ta_stb");
            if (e_ta != 0) check("R3", ta_value, v_ta, "ta_value");
            check("R4", tb_stb, e_tb, "tb_stb");
            if (e_tb != 0) check("R4", tb_value, v_tb, "tb_value");
            check("R5", key_stb, e_key, "key_stb");
            if (e_key != 0) begin
                check("R5", key_chan, v_kc, "key_chan");
                check("R5", key_mask, v_km, "key_mask");
            end
            check("R6", freq_stb, e_frq, "freq_stb");
            if (e_frq != 0) begin
                check("R6", freq_chan, v_fc, "freq_chan");
                check("R6", freq_fnum, v_fn, "freq_fnum");
                check("R6", freq_block, v_fb, "freq_block");
            end
            check("R7", alg_stb, e_alg, "alg_stb");
            if (e_alg != 0) begin
                check("R7", alg_chan, v_ac, "alg_chan");
                check("R7", alg_sel, v_as, "alg_sel");
            end
            check("R8", pcm_en, pen_m, "pcm_en");
            check("R8", pcm_stb, e_pcm, "pcm_stb");
            if (e_pcm != 0) check("R8", pcm_data, v_pd, "pcm_data");
            check("R2", op_stb, e_op, "op_stb");
            if (e_op != 0) begin
                check("R2", op_group, v_og, "op_group");
                check("R2", op_chan, v_oc, "op_chan");
                check("R2", op_idx, v_oi, "op_idx");
                check("R2", op_data, v_od, "op_data");
            end
        end
    end

    // One bus write; returns at the negedge where its strobe is visible
    task automatic wr(input int a, input int d);
        @(negedge clk);
        bus_wr = 1; bus_addr = 2'(a); bus_wdata = 8'(d);
        @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic sel_wr(input int bank, input int r, input int d);
        wr(bank * 2, r);
        wr(bank * 2 + 1, d);
    endtask

    task automatic expect_quiet(input string req);
        check(req, int'({ta_stb, tb_stb, key_stb, freq_stb, alg_stb, pcm_stb, op_stb}), 0, "strobes");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++;
            $display("FAIL watchdog expired");
            finish_report();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state
        expect_quiet("R11");
        check("R11", pcm_en, 0, "pcm_en after reset");
        rst_n = 1;
        @(negedge clk);
        // R1: selection is zero after reset, so data is ignored
        wr(1, 'h55);
        expect_quiet("R1");
        wr(3, 'h55);
        expect_quiet("R1");

        // R3: timer A in both orders
        sel_wr(0, 'h24, 'hAB);
        check("R3", ta_value, 'h2AC, "ta after hi");
        sel_wr(0, 'h25, 'h03);
        check("R3", ta_value, 'h2AF, "ta after lo");
        sel_wr(1, 'h24, 'h01);
        check("R3", ta_value, 'h007, "ta hi keeps lo");
        sel_wr(0, 'h26, 'hC3);

        // R5: key commands
        wr(0, 'h28);
        wr(1, 'hF2);
        wr(1, 'h1C);
        wr(1, 'h07);
        expect_quiet("R5");
        wr(1, 'hA6);
        expect_quiet("R5");

        // R2: full operator range in bank 0, part of bank 1
        for (int r = 'h30; r <= 'h9F; r++) sel_wr(0, r, r ^ 'h5A);
        for (int r = 'h40; r <= 'h4F; r++) sel_wr(1, r, r);
        sel_wr(0, 'h33, 'h11);
        expect_quiet("R10");

        // R6: frequency parts in both orders and banks
        sel_wr(1, 'hA4, 'h2D);
        sel_wr(1, 'hA0, 'h77);
        check("R6", freq_fnum, 'h577, "combined fnum ch3");
        sel_wr(0, 'hA2, 'h12);
        sel_wr(0, 'hA6, 'h3F);
        sel_wr(1, 'hA6, 'h01);
        sel_wr(0, 'hA3, 'h01);
        expect_quiet("R10");
        sel_wr(0, 'hA7, 'h01);
        expect_quiet("R10");

        // R7: algorithm
        for (int c = 0; c < 3; c++) begin
            sel_wr(0, 'hB0 + c, c + 5);
            sel_wr(1, 'hB0 + c, c + 1);
        end
        sel_wr(1, 'hB3, 'h07);
        expect_quiet("R10");

        // R8: PCM gating
        sel_wr(0, 'h2A, 'h80);
        expect_quiet("R8");
        sel_wr(0, 'h2B, 'h80);
        check("R8", pcm_en, 1, "pcm_en set");
        wr(0, 'h2A);
        wr(1, 'h81);
        wr(1, 'hFF);
        sel_wr(1, 'h2B, 'h7F);
        check("R8", pcm_en, 0, "pcm_en cleared");
        sel_wr(0, 'h2A, 'h44);
        expect_quiet("R8");

        // R10: unhandled registers
        sel_wr(0, 'h22, 'hFF);
        expect_quiet("R10");
        sel_wr(0, 'h27, 'hFF);
        expect_quiet("R10");
        sel_wr(1, 'hC0, 'h12);
        expect_quiet("R10");
        sel_wr(1, 'hFF, 'h12);
        expect_quiet("R10");

        // R1: banks keep separate selections
        wr(0, 'h24);
        wr(2, 'h26);
        wr(3, 'h9A);
        check("R1", tb_stb, 1, "bank1 data hits bank1 reg");
        wr(1, 'h10);
        check("R1", ta_stb, 1, "bank0 data hits bank0 reg");
        wr(1, 'h11);
        wr(3, 'h12);

        // R9: status read at every offset
        for (int f = 0; f < 4; f++) begin
            @(negedge clk);
            tmr_a_ovf = f[1]; tmr_b_ovf = f[0];
            bus_rd = 1; bus_addr = 2'(3 - f);
            #1 check("R9", bus_rdata, f, "status");
        end
        @(negedge clk);
        bus_rd = 0;
        #1 check("R9", bus_rdata, 0, "no read");

        // R11: reset mid-run clears selections and frequency parts
        @(negedge clk);
        rst_n = 0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1;
        wr(1, 'h01);
        expect_quiet("R11");
        sel_wr(1, 'hA0, 'h05);
        check("R11", freq_fnum, 'h005, "fnum hi cleared");
        check("R11", freq_block, 0, "block cleared");

        repeat (3) @(negedge clk);
        finish_report();
    end
endmodule